// File: doc/BRIEF.md
# Thermal Shutdown Derating Controller

This block decides how a multi-string LED driver responds when the die gets too hot. It watches three synchronous temperature comparator flags. The hot flag means the shutdown threshold has been crossed. The cool flag means the die has cooled enough to restart. The warn flag means the lower warning threshold has been crossed. From these flags the block drives a global run enable and a 2-bit current-scale code. The run enable gates both the boost converter and every channel current source. The scale code tells the current DAC what fraction of the programmed LED current to use.

Each time the hot flag is sampled, the block stops everything at once. It then waits in a thermal-off state until the cool flag arrives, and restarts with one more quarter step of derating. The first restart runs at three quarters of the set current, the next at one half, and later restarts at one quarter, where it stays. The part never latches off for thermal reasons. Only removing the enable input, or a reset, returns the scale to full current. The warning flag never stops operation; it is only passed on, one register later, to the channel fault logic.

Top module: `thd_derate_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), run_o is 0, scale_o is 2'b00 and warn_o is 0.
- R2: While en_i is high and hot_i is low, the block leaves the disabled state and run_o rises at the clock edge that samples en_i high.
- R3: When en_i is high and hot_i is sampled high at a clock edge, run_o is 0 right after that edge. It stays 0 while cool_i is low.
- R4: In the thermal-off state, a clock edge that samples cool_i high and hot_i low sets run_o to 1 at that edge.
- R5: The scale code encoding is 2'b00 = 100%, 2'b01 = 75%, 2'b10 = 50%, 2'b11 = 25%. Each over-temperature event (hot_i sampled high while not already thermally off) raises the code by one at that same edge.
- R6: Once the code is 2'b11, further trips keep it at 2'b11, and the off/cool cycle still repeats.
- R7: cool_i has no effect unless the block is thermally off. While the block is thermally off and hot_i is still high, cool_i does not restart it.
- R8: When en_i is sampled low, run_o and scale_o go to 0 and 2'b00 at that edge. A later re-enable starts at full current.
- R9: warn_o equals warn_i delayed by one clock while en_i is high, and is 0 after an edge that samples en_i low. warn_i never changes run_o or scale_o.
- R10: While en_i is high and hot_i is low, scale_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Block enable; low clears the derating |
| hot_i | input | 1 | Upper shutdown comparator flag |
| cool_i | input | 1 | Restart (cooled) comparator flag |
| warn_i | input | 1 | Lower warning comparator flag |
| run_o | output | 1 | Gates boost switching and current sources |
| scale_o | output | 2 | Current scale code (00 full, 11 quarter) |
| warn_o | output | 1 | Registered warning to channel fault logic |

## Verification
A wrong step counter shows up on scale_o at the very edge that samples a trip. Examples are a skipped step, a wrap from quarter back to full current, or a clear that happens on a trip. A wrong sequencer state shows up on run_o within one clock. The block might ignore cool_i while off, act on it while running, or restart with the hot flag still high. Because both outputs are registered, every such fault is visible one edge after the stimulus that exposes it. The bench therefore compares both outputs on every cycle against a model.

// File: rtl/thd_pkg.sv
// Shared types for the thermal derating controller.
// Assumes all comparator flags are already synchronous to clk.
package thd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // disabled
        ST_RUN  = 2'd1,   // operating
        ST_HOT  = 2'd2    // thermally off, waiting for cool flag
    } thd_state_e;
endpackage

// File: rtl/thd_seq_fsm.sv
// Sequencer: tracks disabled / running / thermally-off.
// Emits a one-cycle trip event on each new over-temperature entry.
// Assumes en, hot and cool are synchronous single-bit levels.
module thd_seq_fsm
    import thd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hot,
    input  logic cool,
    output logic run,
    output logic trip_evt
);
    thd_state_e st_q, st_d;

    // New over-temperature event: enabled, hot, not already off.
    assign trip_evt = en && hot && (st_q != ST_HOT);

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        if (!en)
            st_d = ST_IDLE;
        else if (trip_evt)
            st_d = ST_HOT;
        else if (st_q == ST_HOT && cool && !hot)
            st_d = ST_RUN;
        else if (st_q == ST_IDLE)
            st_d = ST_RUN;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Run is on only in the operating state.
    assign run = (st_q == ST_RUN);
endmodule

// File: rtl/thd_derate_step.sv
// Saturating derating step counter: one step per trip, cleared on disable.
// Assumes step and clr are never needed in the same cycle (clr wins).
module thd_derate_step #(
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [LVL_W-1:0] level
);
    localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

    // Count trips, hold at the deepest derating level.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            level <= '0;
        else if (step && level != LVL_MAX)
            level <= level + 1'b1;
    end
endmodule

// File: rtl/thd_warn_fwd.sv
// Forwards the lower warning flag to channel fault logic, one register late.
// Assumes warn is synchronous; output is forced low while disabled.
module thd_warn_fwd (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic warn_in,
    output logic warn_out
);
    // Register the warning, masked by enable.
    always_ff @(posedge clk) begin
        if (!rst_n) warn_out <= 1'b0;
        else        warn_out <= en && warn_in;
    end
endmodule

// File: rtl/thd_derate_top.sv
// Thermal shutdown derating controller top.
// Stops everything on each upper trip, restarts on the cool flag with one
// more quarter step of current reduction, and forwards the lower warning.
// Assumes comparator flags are synchronous to clk.
module thd_derate_top #(
    parameter int SCALE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               hot_i,
    input  logic               cool_i,
    input  logic               warn_i,
    output logic               run_o,
    output logic [SCALE_W-1:0] scale_o,
    output logic               warn_o
);
    logic trip_evt;

    thd_seq_fsm u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_i),
        .hot      (hot_i),
        .cool     (cool_i),
        .run      (run_o),
        .trip_evt (trip_evt)
    );

    thd_derate_step #(.LVL_W(SCALE_W)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!en_i),
        .step  (trip_evt),
        .level (scale_o)
    );

    thd_warn_fwd u_warn (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_i),
        .warn_in  (warn_i),
        .warn_out (warn_o)
    );
endmodule

// File: rtl/thd_derate_chk.sv
// Port-level properties of the derating controller, bound to the top.
module thd_derate_chk #(
    parameter int SCALE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en_i,
    input logic               hot_i,
    input logic               cool_i,
    input logic               warn_i,
    input logic               run_o,
    input logic [SCALE_W-1:0] scale_o,
    input logic               warn_o
);
    localparam logic [SCALE_W-1:0] SMAX = {SCALE_W{1'b1}};

    AST_TRIP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && hot_i) |=> !run_o);                                   // R3
    AST_TRIP_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && hot_i && run_o && scale_o != SMAX) |=>
        (scale_o == $past(scale_o) + 1'b1));                           // R5
    AST_SCALE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && scale_o == SMAX) |=> (scale_o == SMAX));              // R6
    AST_COOL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && run_o && !hot_i) |=> run_o);                          // R7
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!run_o && scale_o == '0 && !warn_o));               // R8
    AST_WARN_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && warn_i) |=> warn_o);                                  // R9
    AST_SCALE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !hot_i) |=> $stable(scale_o));                        // R10
endmodule

bind thd_derate_top thd_derate_chk #(.SCALE_W(SCALE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .hot_i   (hot_i),
    .cool_i  (cool_i),
    .warn_i  (warn_i),
    .run_o   (run_o),
    .scale_o (scale_o),
    .warn_o  (warn_o)
);

// File: tb/sim_thd_derate_top.sv
module sim_thd_derate_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0, hot_i = 1'b0, cool_i = 1'b0, warn_i = 1'b0;
    logic       run_o, warn_o;
    logic [1:0] scale_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // model state: 0 idle, 1 run, 2 hot
    int         m_st  = 0;
    logic [1:0] m_lvl = 2'b00;
    logic       m_warn = 1'b0;

    thd_derate_top u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .hot_i(hot_i),
        .cool_i(cool_i), .warn_i(warn_i), .run_o(run_o),
        .scale_o(scale_o), .warn_o(warn_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    function automatic int next_st(int st, logic en, logic hot, logic cool);
        if (!en) return 0;
        if (hot && st != 2) return 2;
        if (st == 2 && cool && !hot) return 1;
        if (st == 0) return 1;
        return st;
    endfunction

    function automatic logic [1:0] next_lvl(int st, logic [1:0] lvl, logic en, logic hot);
        if (!en) return 2'b00;
        if (hot && st != 2 && lvl != 2'b11) return lvl + 2'b01;
        return lvl;
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s run/scale/warn act=%b exp=%b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // One clock: apply inputs at negedge, update model at posedge, compare after.
    task automatic cyc(string tag, logic en, logic hot, logic cool, logic warn);
        @(negedge clk);
        en_i = en; hot_i = hot; cool_i = cool; warn_i = warn;
        @(posedge clk);
        if (!rst_n) begin
            m_st = 0; m_lvl = 2'b00; m_warn = 1'b0;
        end else begin
            m_lvl  = next_lvl(m_st, m_lvl, en, hot);
            m_st   = next_st(m_st, en, hot, cool);
            m_warn = en && warn;
        end
        #2;
        chk(tag, {run_o, scale_o, warn_o}, {(m_st == 1), m_lvl, m_warn});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd7331));
        // R1: reset state
        rst_n = 1'b0;
        cyc("R1", 1, 1, 1, 1);
        cyc("R1", 1, 0, 1, 1);
        rst_n = 1'b1;
        cyc("R8", 0, 0, 0, 0);
        // R2: enable starts run at full scale
        cyc("R2", 1, 0, 0, 0);
        cyc("R2", 1, 0, 1, 0);      // R7: cool while running ignored
        // R3/R5: first trip -> off, 75%
        cyc("R3", 1, 1, 0, 0);
        cyc("R3", 1, 0, 0, 0);
        cyc("R7", 1, 1, 1, 0);      // cool with hot still high: stays off
        cyc("R4", 1, 0, 1, 0);      // restart
        cyc("R9", 1, 0, 0, 1);      // warning forwarded, no effect
        cyc("R9", 1, 0, 0, 0);
        // R5/R6: walk to quarter and saturate
        for (int k = 0; k < 5; k++) begin
            cyc("R5", 1, 1, 0, 0);
            cyc("R6", 1, 0, 0, 0);
            cyc("R4", 1, 0, 1, 0);
            cyc("R10", 1, 0, 0, 1);
        end
        // R8: disable clears, re-enable at full current
        cyc("R8", 0, 0, 0, 1);
        cyc("R8", 1, 0, 0, 0);
        cyc("R2", 1, 0, 0, 0);
        // R1 again mid-derating
        cyc("R5", 1, 1, 0, 0);
        rst_n = 1'b0;
        cyc("R1", 1, 0, 0, 0);
        rst_n = 1'b1;
        // constrained random
        for (int i = 0; i < 20000; i++) begin
            logic en, hot, cool, warn;
            en   = ($urandom % 100) < 97;
            hot  = ($urandom % 100) < 6;
            cool = ($urandom % 100) < 30;
            warn = ($urandom % 100) < 20;
            cyc("R10", en, hot, cool, warn);
        end
        summary();
    end
endmodule